// File: doc/BRIEF.md
# Synchronized Sleep-Mode Controller

This block governs the low-power sleep state of a synchronous memory. An asynchronous, active-high sleep request passes through a multi-flop synchronizer. The controller then runs a short entry window. During that window the data outputs are already forced non-driven, and any access still pending is marked as void. Once the window ends, the power-down output is raised.

When the request falls, the controller leaves sleep through a recovery window. During recovery, access commands stay blocked and the outputs stay non-driven. When recovery ends, the memory may be used again.

The controller also watches the command inputs. It raises a sticky error flag in three cases: a write is seen while the memory sleeps or recovers, the memory is selected while it sleeps or recovers, or sleep is requested while the memory is still selected.

Top module: `slp_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, sleep_active, access_block, out_disable, acc_void and err are all 0.
- R2: When sleep_req rises while idle, out_disable becomes 1 after the 3rd rising clock edge; access_block and sleep_active stay 0 during the entry window. This count covers two synchronizer flops plus one state register.
- R3: sleep_active becomes 1 ENTRY_CYC (default 2) rising edges after out_disable rose, that is, after the 5th edge following the request.
- R4: When sleep_req falls while asleep, sleep_active becomes 0 after the 3rd rising edge. access_block and out_disable stay 1 for EXIT_CYC (default 2) further edges, then fall after the 5th edge.
- R5: Whenever sleep_active is 1, access_block and out_disable are also 1.
- R6: acc_void pulses for exactly the one cycle in which sleep_active first becomes 1, and only if acc_pending was 1 at any rising edge during the entry window. Without a pending access it stays 0.
- R7: A write (wr_cmd=1) or a selection (desel=0) sampled while asleep or recovering sets err to 1 at that edge. err then holds 1 until reset.
- R8: If the synchronized request is first seen while the device is selected (desel=0), err is set at that edge (the 3rd edge after the request rises).
- R9: If the synchronized request returns high during recovery, the controller goes straight back to sleep. With a one-cycle low pulse on sleep_req, sleep_active is 0 after the 3rd edge and 1 again after the 4th, while access_block stays 1 throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| desel | input | 1 | 1 when the memory is deselected |
| wr_cmd | input | 1 | 1 when a write command is presented |
| acc_pending | input | 1 | 1 while an access is still in progress |
| sleep_active | output | 1 | Power-down state is in force |
| access_block | output | 1 | Access commands must be rejected |
| out_disable | output | 1 | Data outputs forced non-driven |
| acc_void | output | 1 | One-cycle mark that a pending access was invalidated |
| err | output | 1 | Sticky protocol violation flag |

## Verification
The assertions take two things for granted about the inputs. First, reset is held for several cycles, so no past value sampled before reset leaks into a check. Second, every input changes away from the rising edge, so the synchronizer captures clean levels. The stimulus meets both conditions: it changes every input on the falling edge and holds reset for three cycles. Its shortest request pulse is one full cycle, which is enough to exercise the re-entry path from recovery. The vectors keep desel high and wr_cmd low around the transitions, except where a violation is injected on purpose to set the error flag.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_ENTER   = 2'd1,
    ST_ASLEEP  = 2'd2,
    ST_RECOVER = 2'd3
  } slp_state_e;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/slp_window_cnt.sv
module slp_window_cnt #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_s,
  input  logic desel,
  input  logic wr_cmd,
  input  logic acc_pending,
  output logic sleep_active,
  output logic access_block,
  output logic out_disable,
  output logic acc_void,
  output logic err
);
  localparam int MAXW = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int CW   = (MAXW < 2) ? 1 : $clog2(MAXW);
  localparam logic [CW-1:0] ENTRY_LD = CW'(ENTRY_CYC - 1);
  localparam logic [CW-1:0] EXIT_LD  = CW'(EXIT_CYC - 1);

  slp_state_e    state, nxt;
  logic          cnt_load;
  logic [CW-1:0] cnt_val;
  logic          cnt_zero;
  logic          pend_seen;
  logic          viol;

  slp_window_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  always_comb begin
    nxt      = state;
    cnt_load = 1'b0;
    cnt_val  = ENTRY_LD;
    unique case (state)
      ST_AWAKE: begin
        if (req_s) begin
          nxt      = ST_ENTER;
          cnt_load = 1'b1;
          cnt_val  = ENTRY_LD;
        end
      end
      ST_ENTER: begin
        if (cnt_zero) nxt = ST_ASLEEP;
      end
      ST_ASLEEP: begin
        if (!req_s) begin
          nxt      = ST_RECOVER;
          cnt_load = 1'b1;
          cnt_val  = EXIT_LD;
        end
      end
      ST_RECOVER: begin
        if (req_s)         nxt = ST_ASLEEP;
        else if (cnt_zero) nxt = ST_AWAKE;
      end
      default: nxt = ST_AWAKE;
    endcase
  end

  always_comb begin
    viol = 1'b0;
    if ((state == ST_ASLEEP || state == ST_RECOVER) && (!desel || wr_cmd))
      viol = 1'b1;
    if (state == ST_AWAKE && req_s && !desel)
      viol = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_AWAKE;
      pend_seen    <= 1'b0;
      sleep_active <= 1'b0;
      access_block <= 1'b0;
      out_disable  <= 1'b0;
      acc_void     <= 1'b0;
      err          <= 1'b0;
    end else begin
      state        <= nxt;
      pend_seen    <= (state == ST_ENTER) && (pend_seen || acc_pending);
      sleep_active <= (nxt == ST_ASLEEP);
      access_block <= (nxt == ST_ASLEEP) || (nxt == ST_RECOVER);
      out_disable  <= (nxt != ST_AWAKE);
      acc_void     <= (state == ST_ENTER) && (nxt == ST_ASLEEP) &&
                      (pend_seen || acc_pending);
      err          <= err || viol;
    end
  end
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int EXIT_CYC    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_req,
  input  logic desel,
  input  logic wr_cmd,
  input  logic acc_pending,
  output logic sleep_active,
  output logic access_block,
  output logic out_disable,
  output logic acc_void,
  output logic err
);
  logic req_s;

  slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sleep_req),
    .q   (req_s)
  );

  slp_fsm #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .req_s        (req_s),
    .desel        (desel),
    .wr_cmd       (wr_cmd),
    .acc_pending  (acc_pending),
    .sleep_active (sleep_active),
    .access_block (access_block),
    .out_disable  (out_disable),
    .acc_void     (acc_void),
    .err          (err)
  );
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic desel,
  input logic wr_cmd,
  input logic sleep_active,
  input logic access_block,
  input logic out_disable,
  input logic acc_void,
  input logic err
);
  assert_cover_outputs_R5: assert property (@(posedge clk) disable iff (rst)
    sleep_active |-> (access_block && out_disable));

  assert_entry_window_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_active) |-> $past(out_disable));

  assert_exit_guard_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_active) |-> (access_block && out_disable));

  assert_void_on_entry_R6: assert property (@(posedge clk) disable iff (rst)
    acc_void |-> $rose(sleep_active));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_write_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (sleep_active && (wr_cmd || !desel)) |=> err);
endmodule

bind slp_ctrl slp_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .desel        (desel),
  .wr_cmd       (wr_cmd),
  .sleep_active (sleep_active),
  .access_block (access_block),
  .out_disable  (out_disable),
  .acc_void     (acc_void),
  .err          (err)
);

// File: tb/tb_slp_ctrl.sv
module tb_slp_ctrl;
  logic clk = 1'b0;
  logic rst, sleep_req, desel, wr_cmd, acc_pending;
  logic sleep_active, access_block, out_disable, acc_void, err;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  slp_ctrl dut (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .desel(desel),
    .wr_cmd(wr_cmd), .acc_pending(acc_pending),
    .sleep_active(sleep_active), .access_block(access_block),
    .out_disable(out_disable), .acc_void(acc_void), .err(err)
  );

  // bits: [8] req [7] desel [6] wr [5] pend | [4] sleep [3] block [2] disable [1] void [0] err
  localparam int NV = 12;
  localparam logic [8:0] VEC [0:NV-1] = '{
    9'b1100_00000, 9'b1100_00000, 9'b1100_00100, 9'b1101_00100,
    9'b1100_11110, 9'b1100_11100, 9'b0100_11100, 9'b0100_11100,
    9'b0100_01100, 9'b0100_01100, 9'b0100_00000, 9'b0100_00000
  };

  task automatic chk(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset();
    rst = 1'b1; sleep_req = 1'b0; desel = 1'b1; wr_cmd = 1'b0; acc_pending = 1'b0;
    steps(3);
    chk("R1 sleep_active", sleep_active, 1'b0);
    chk("R1 access_block", access_block, 1'b0);
    chk("R1 out_disable", out_disable, 1'b0);
    chk("R1 acc_void", acc_void, 1'b0);
    chk("R1 err", err, 1'b0);
    rst = 1'b0;
    step();
    chk("R1 sleep_active after release", sleep_active, 1'b0);
    chk("R1 out_disable after release", out_disable, 1'b0);
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R2 R3 R4 R6: full entry and exit walked from the table
    for (int v = 0; v < NV; v++) begin
      sleep_req   = VEC[v][8];
      desel       = VEC[v][7];
      wr_cmd      = VEC[v][6];
      acc_pending = VEC[v][5];
      step();
      chk($sformatf("R3 vec%0d sleep_active", v), sleep_active, VEC[v][4]);
      chk($sformatf("R5 vec%0d access_block", v), access_block, VEC[v][3]);
      chk($sformatf("R2 vec%0d out_disable", v), out_disable, VEC[v][2]);
      chk($sformatf("R6 vec%0d acc_void", v), acc_void, VEC[v][1]);
      chk($sformatf("R4 vec%0d err", v), err, VEC[v][0]);
    end

    // R8: request while selected
    do_reset();
    desel = 1'b0; sleep_req = 1'b1;
    steps(2);
    chk("R8 err before detect", err, 1'b0);
    step();
    chk("R8 err at detect", err, 1'b1);

    // R7: write while asleep, then sticky
    do_reset();
    sleep_req = 1'b1;
    steps(5);
    chk("R7 asleep", sleep_active, 1'b1);
    chk("R7 err clean", err, 1'b0);
    wr_cmd = 1'b1;
    step();
    chk("R7 err after write", err, 1'b1);
    wr_cmd = 1'b0;
    steps(2);
    chk("R7 err sticky", err, 1'b1);

    // R7: selection during recovery
    do_reset();
    sleep_req = 1'b1;
    steps(5);
    sleep_req = 1'b0;
    steps(3);
    chk("R7 recovering sleep", sleep_active, 1'b0);
    chk("R7 recovering block", access_block, 1'b1);
    chk("R7 err before select", err, 1'b0);
    desel = 1'b0;
    step();
    chk("R7 err on select in recovery", err, 1'b1);

    // R6 negative and R9 re-entry from recovery
    do_reset();
    sleep_req = 1'b1;
    steps(5);
    chk("R6 asleep", sleep_active, 1'b1);
    chk("R6 no void without pending", acc_void, 1'b0);
    sleep_req = 1'b0;
    step();
    sleep_req = 1'b1;
    step();
    chk("R9 still asleep", sleep_active, 1'b1);
    step();
    chk("R9 recover sleep", sleep_active, 1'b0);
    chk("R9 recover block", access_block, 1'b1);
    step();
    chk("R9 back asleep", sleep_active, 1'b1);
    chk("R9 block held", access_block, 1'b1);
    chk("R9 err clean", err, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule